// File: doc/BRIEF.md
# Streaming Sobel Edge Filter

This block takes a raster-order stream of 8-bit grey pixels, one per clock when its valid strobe is high. It produces a stream of 8-bit edge strengths. A single shift chain of 2*W+3 pixel registers holds the newest two image rows plus three pixels. Nine fixed taps of that chain form a 3x3 neighbourhood. The chain moves only when a pixel is accepted, so the neighbourhood always consists of real, adjacent image samples. Once the chain has filled for the current frame, every accepted pixel yields one result, so the block sustains one output per clock.

The result is the sum of the absolute horizontal and vertical Sobel gradients, clipped to 255. Two register stages carry the arithmetic, and the valid and end-of-frame flags travel with the data through those stages. A window whose centre sits in the first or last image column is forced to zero, because such a window straddles the end of one row and the start of the next.

Image width and height are parameters. The defaults are a 640-pixel wide, 480-line frame. The block counts its own column and row positions, so no frame-start input is needed.

Top module: `sobel_edge`

## Requirements
- R1: While `rst` is high at a rising edge, the shift chain, the position counters and all pipeline registers clear. After that edge `out_valid` and `out_eof` read 0 and `out_pix` reads 0.
- R2: In each frame, the first 2*W+2 accepted pixels produce no result. Every later accepted pixel produces exactly one result, so a frame yields W*H-2*W-2 results.
- R3: A clock with `in_valid` low leaves the chain and the position counters unchanged, whatever `in_pix` carries. Idle gaps of any length between pixels do not change the results.
- R4: For the window whose newest pixel is at row r and column c, Gx is the right column (c) minus the left column (c-2), weighted 1,2,1 over rows r-2..r. Gy is the bottom row (r) minus the top row (r-2), weighted 1,2,1 over columns c-2..c. The result is |Gx|+|Gy|.
- R5: When |Gx|+|Gy| exceeds 255, the result is exactly 255.
- R6: When the newest pixel's column is 0 or 1, the window centre lies on the last or first image column, and the result is 0.
- R7: The result for a pixel accepted at rising edge n appears on the outputs after rising edge n+2.
- R8: `out_eof` is 1 on the result of the pixel at row H-1, column W-1, and 0 on every other result. After that pixel, the next accepted pixel is row 0, column 0 of a new frame, and the fill rule of R2 starts again.
- R9: A reset in the middle of a frame discards the partial frame. The next accepted pixel is treated as row 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | `in_pix` carries a pixel this clock |
| in_pix | input | 8 | Grey pixel, raster order |
| out_valid | output | 1 | `out_pix` carries a result this clock |
| out_pix | output | 8 | Saturated gradient magnitude |
| out_eof | output | 1 | Result belongs to the last pixel of the frame |

## Verification
The hardest situation to reach from the ports is a window that straddles a row boundary while it also holds strong edges. That is the only case in which the column masking changes the answer. The stimulus uses a vertical step image that is dark in the left columns and bright in the right ones. Each wrapped window then holds a full-swing transition that would saturate if it were not masked. A second frame mixes random idle gaps, carrying garbage data, with random pixels. This shows that stalls alter neither the window nor the frame position.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

    localparam int PIX_W  = 8;
    localparam int GRAD_W = PIX_W + 3;

    typedef logic [PIX_W-1:0]         pix_t;
    typedef logic signed [GRAD_W-1:0] grad_t;
    typedef logic [GRAD_W-1:0]        umag_t;

    // [row][col]; index 0 is the newest row / newest column
    typedef pix_t [2:0][2:0] win_t;

    typedef struct packed {
        logic valid;
        logic eof;
        logic edge_col;
    } tag_t;

    function automatic grad_t widen(input pix_t p);
        return $signed({3'b000, p});
    endfunction

    // 1-2-1 weighted sum of three samples
    function automatic grad_t tri_sum(input pix_t a, input pix_t b, input pix_t c);
        return widen(a) + (widen(b) <<< 1) + widen(c);
    endfunction

    function automatic umag_t mag(input grad_t g);
        return g[GRAD_W-1] ? $unsigned(-g) : $unsigned(g);
    endfunction

    function automatic pix_t clip(input logic [GRAD_W:0] s);
        return (|s[GRAD_W:PIX_W]) ? '1 : s[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/sobel_window.sv
module sobel_window
    import sobel_pkg::*;
#(
    parameter int IMG_W = 640
) (
    input  logic clk,
    input  logic rst,
    input  logic shift_en,
    input  pix_t din,
    output win_t win
);
    localparam int DEPTH = 2 * IMG_W + 3;

    pix_t line_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q[0] <= '0;
        end else if (shift_en) begin
            line_q[0] <= din;
        end
    end

    for (genvar gi = 1; gi < DEPTH; gi++) begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) begin
                line_q[gi] <= '0;
            end else if (shift_en) begin
                line_q[gi] <= line_q[gi-1];
            end
        end
    end

    for (genvar gr = 0; gr < 3; gr++) begin : g_row
        for (genvar gc = 0; gc < 3; gc++) begin : g_col
            assign win[gr][gc] = line_q[gr*IMG_W + gc];
        end
    end

    logic live_q;
    always_ff @(posedge clk) live_q <= !rst;

    // R3: no accepted pixel, no movement of the window
    a_r3_hold_window: assert property (@(posedge clk) disable iff (rst || !live_q)
        !$past(shift_en) |-> $stable(win));

    // R3: an accepted pixel moves the newest sample one tap along
    a_r3_shift_step: assert property (@(posedge clk) disable iff (rst || !live_q)
        $past(shift_en) |-> (win[0][1] == $past(win[0][0])));

endmodule

// File: rtl/sobel_raster.sv
module sobel_raster
    import sobel_pkg::*;
#(
    parameter int IMG_W = 640,
    parameter int IMG_H = 480
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output tag_t tag_q
);
    localparam int FILL  = 2 * IMG_W + 2;
    localparam int COL_W = $clog2(IMG_W);
    localparam int ROW_W = $clog2(IMG_H);
    localparam int CNT_W = $clog2(FILL + 1);

    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;
    logic [CNT_W-1:0] cnt_q;

    logic last_col, last_row, last_pix, filled;
    assign last_col = (col_q == COL_W'(IMG_W - 1));
    assign last_row = (row_q == ROW_W'(IMG_H - 1));
    assign last_pix = last_col && last_row;
    assign filled   = (cnt_q == CNT_W'(FILL));

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
            row_q <= '0;
            cnt_q <= '0;
            tag_q <= '0;
        end else begin
            tag_q.valid    <= in_valid && filled;
            tag_q.eof      <= in_valid && last_pix;
            tag_q.edge_col <= (col_q < COL_W'(2));
            if (in_valid) begin
                if (last_pix) begin
                    col_q <= '0;
                    row_q <= '0;
                    cnt_q <= '0;
                end else begin
                    col_q <= last_col ? '0 : col_q + 1'b1;
                    row_q <= last_col ? row_q + 1'b1 : row_q;
                    if (!filled) cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    a_r8_eof_restarts: assert property (@(posedge clk) disable iff (rst)
        tag_q.eof |-> (cnt_q == '0 && col_q == '0 && row_q == '0));

    a_r8_eof_has_result: assert property (@(posedge clk) disable iff (rst)
        tag_q.eof |-> tag_q.valid);

    a_r2_fill_held: assert property (@(posedge clk) disable iff (rst)
        (tag_q.valid && !tag_q.eof) |-> filled);

endmodule

// File: rtl/sobel_kernel.sv
module sobel_kernel
    import sobel_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  win_t win,
    input  tag_t tag,
    output logic out_valid,
    output logic out_eof,
    output pix_t out_pix
);
    grad_t gx_c, gy_c, gx_q, gy_q;
    tag_t  tag1_q;

    always_comb begin
        gx_c = tri_sum(win[0][0], win[1][0], win[2][0])
             - tri_sum(win[0][2], win[1][2], win[2][2]);
        gy_c = tri_sum(win[0][0], win[0][1], win[0][2])
             - tri_sum(win[2][0], win[2][1], win[2][2]);
    end

    // stage 1: signed gradients, masked on wrapped columns
    always_ff @(posedge clk) begin
        if (rst) begin
            gx_q   <= '0;
            gy_q   <= '0;
            tag1_q <= '0;
        end else begin
            gx_q   <= tag.edge_col ? '0 : gx_c;
            gy_q   <= tag.edge_col ? '0 : gy_c;
            tag1_q <= tag;
        end
    end

    // stage 2: magnitude and clip
    logic [GRAD_W:0] sum_c;
    assign sum_c = {1'b0, mag(gx_q)} + {1'b0, mag(gy_q)};

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_eof   <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= tag1_q.valid;
            out_eof   <= tag1_q.eof;
            out_pix   <= clip(sum_c);
        end
    end

    a_r6_edge_zero: assert property (@(posedge clk) disable iff (rst)
        (tag1_q.valid && tag1_q.edge_col) |=> (out_pix == '0));

    a_r5_clip_high: assert property (@(posedge clk) disable iff (rst)
        (tag1_q.valid && (gx_q >= grad_t'(255) || gx_q <= grad_t'(-255))) |=> (out_pix == 8'hFF));

    a_r7_two_stages: assert property (@(posedge clk) disable iff (rst)
        tag.valid |=> ##1 out_valid);

endmodule

// File: rtl/sobel_edge.sv
module sobel_edge
    import sobel_pkg::*;
#(
    parameter int IMG_W = 640,
    parameter int IMG_H = 480
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_pix,
    output logic       out_valid,
    output logic [7:0] out_pix,
    output logic       out_eof
);
    win_t win;
    tag_t tag;

    sobel_window #(.IMG_W(IMG_W)) u_window (
        .clk      (clk),
        .rst      (rst),
        .shift_en (in_valid),
        .din      (in_pix),
        .win      (win)
    );

    sobel_raster #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_raster (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .tag_q    (tag)
    );

    sobel_kernel u_kernel (
        .clk       (clk),
        .rst       (rst),
        .win       (win),
        .tag       (tag),
        .out_valid (out_valid),
        .out_eof   (out_eof),
        .out_pix   (out_pix)
    );

endmodule

// File: tb/sobel_edge_bench.sv
`timescale 1ns/1ps
module sobel_edge_bench;
    localparam int W    = 8;
    localparam int H    = 6;
    localparam int FILL = 2 * W + 2;
    localparam int NRES = W * H - FILL;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_pix = '0;
    logic       out_valid;
    logic [7:0] out_pix;
    logic       out_eof;

    always #2.5 clk = ~clk;

    sobel_edge #(.IMG_W(W), .IMG_H(H)) u_sobel_edge (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_pix(in_pix),
        .out_valid(out_valid), .out_pix(out_pix), .out_eof(out_eof)
    );

    int    n_chk = 0, n_fail = 0;
    int    n_out = 0, n_eof = 0;
    int    img [H][W];
    int    exp_q[$];
    bit    eofx_q[$];
    string req_q[$];
    bit    done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sobel_ref(input int r, input int c);
        int gx = 0, gy = 0, s;
        if (c < 2) return 0;
        for (int d = 0; d < 3; d++) begin
            int w = (d == 1) ? 2 : 1;
            gx += w * (img[r-2+d][c] - img[r-2+d][c-2]);
            gy += w * (img[r][c-2+d] - img[r-2][c-2+d]);
        end
        s = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
        return (s > 255) ? 255 : s;
    endfunction

    // monitor: compares every result in order
    int    m_e;
    bit    m_ee;
    string m_t;
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            n_out++;
            if (out_eof) n_eof++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected result", out_pix, -1);
            end else begin
                m_e  = exp_q.pop_front();
                m_ee = eofx_q.pop_front();
                m_t  = req_q.pop_front();
                chk(out_pix == m_e[7:0], m_t, "edge value", out_pix, m_e);
                chk(out_eof == m_ee, "R8", "eof flag", out_eof, m_ee);
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_pix   = 8'($urandom);
    endtask

    task automatic fill_img(input int pat);
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++)
                case (pat)
                    0: img[r][c] = 77;
                    1: img[r][c] = c * 20 + r * 7;
                    2: img[r][c] = int'($urandom_range(0, 255));
                    default: img[r][c] = (c >= 4) ? 255 : 0;
                endcase
    endtask

    // drives a frame; gaps inserts random idles; lat checks R7 on the last pixel
    task automatic drive_frame(input int pat, input bit gaps, input int stop_at, input bit lat);
        fill_img(pat);
        n_out = 0;
        n_eof = 0;
        for (int k = 0; k < W * H && k < stop_at; k++) begin
            int r = k / W, c = k % W;
            if (gaps) repeat ($urandom_range(0, 2)) idle();
            if (lat && k == W * H - 1) repeat (6) idle();
            if (k >= FILL) begin
                int e = sobel_ref(r, c);
                exp_q.push_back(e);
                eofx_q.push_back(k == W * H - 1);
                req_q.push_back(c < 2 ? "R6" : (e == 255 ? "R5" : "R4"));
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_pix   = img[r][c][7:0];
            if (lat && k == W * H - 1) begin
                idle();
                chk(out_valid == 1'b0, "R7", "valid one edge after", out_valid, 0);
                idle();
                chk(out_valid == 1'b0, "R7", "valid two edges after", out_valid, 0);
                idle();
                chk(out_valid && out_eof, "R7", "result after third edge", out_valid, 1);
            end
        end
        repeat (6) idle();
    endtask

    task automatic frame_end_checks(input string req);
        chk(exp_q.size() == 0, req, "results missing", exp_q.size(), 0);
        chk(n_out == NRES, "R2", "results per frame", n_out, NRES);
        chk(n_eof == 1, "R8", "eof count per frame", n_eof, 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
        chk(out_pix == 8'd0, "R1", "pixel in reset", out_pix, 0);
        chk(out_eof == 1'b0, "R1", "eof in reset", out_eof, 0);
        rst = 1'b0;
        idle();
    endtask

    task automatic t_flat();      drive_frame(0, 1'b0, W * H, 1'b0); frame_end_checks("R4"); endtask
    task automatic t_ramp();      drive_frame(1, 1'b0, W * H, 1'b0); frame_end_checks("R4"); endtask
    task automatic t_step_wrap(); drive_frame(3, 1'b0, W * H, 1'b0); frame_end_checks("R6"); endtask
    task automatic t_gaps();      drive_frame(2, 1'b1, W * H, 1'b0); frame_end_checks("R3"); endtask
    task automatic t_latency();   drive_frame(2, 1'b0, W * H, 1'b1); frame_end_checks("R7"); endtask

    task automatic t_back_to_back();
        // R8: consecutive frames with no idle between them
        fill_img(2);
        n_out = 0;
        n_eof = 0;
        for (int f = 0; f < 2; f++) begin
            for (int k = 0; k < W * H; k++) begin
                int r = k / W, c = k % W;
                if (k >= FILL) begin
                    int e = sobel_ref(r, c);
                    exp_q.push_back(e);
                    eofx_q.push_back(k == W * H - 1);
                    req_q.push_back(c < 2 ? "R6" : "R8");
                end
                @(negedge clk);
                in_valid = 1'b1;
                in_pix   = img[r][c][7:0];
            end
        end
        repeat (6) idle();
        chk(exp_q.size() == 0, "R8", "results missing", exp_q.size(), 0);
        chk(n_out == 2 * NRES, "R8", "results over two frames", n_out, 2 * NRES);
        chk(n_eof == 2, "R8", "eof over two frames", n_eof, 2);
    endtask

    task automatic t_mid_reset();
        // R9: partial frame, reset, then a full frame from row 0
        drive_frame(1, 1'b0, W * 3 + 3, 1'b0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        idle();
        chk(out_valid == 1'b0, "R9", "valid after reset", out_valid, 0);
        drive_frame(3, 1'b0, W * H, 1'b0);
        frame_end_checks("R9");
    endtask

    initial begin
        t_reset();
        t_flat();
        t_ramp();
        t_step_wrap();
        t_gaps();
        t_latency();
        t_back_to_back();
        t_mid_reset();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule